// File: doc/BRIEF.md
# Expansion Bus I/O Gate

This block sits between the host CPU's I/O cycles and an external expansion edge connector. For every I/O cycle it decides whether an internal device answers it or whether the cycle is passed out to the connector. Cycles that an enabled internal device claims never show up on the connector. The connector side stays idle and neutral until software turns the bus on. While it is on, the CPU clock is held at its slowest setting so that legacy peripherals keep up.

Two internal devices are considered. The first is the partially decoded even-port device, which answers every address with bit 0 low. The second is the sound device, which answers two fixed 16-bit ports. Software can switch off either device through a small control register. A peripheral on the connector can also drive an inhibit line to push the even-port device aside. The block samples that line while the I/O strobe is still inactive and keeps the sampled value for the rest of the cycle, so the line has to settle before the strobe falls.

Top module: `xbus_io_gate`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it is released, the control register reads 0. The bus is therefore off, both internal devices are on, and the clock speed request passes through unchanged.
- R2: While control bit 0 (bus on) is 0, bus_iorq_n, bus_rd_n and bus_wr_n are 1 and bus_addr is 0, whatever the CPU does.
- R3: While control bit 0 is 1, speed_eff is 2'b00 (the slowest setting). While it is 0, speed_eff equals speed_req (2'b00 slowest up to 2'b11 fastest).
- R4: The even-port device claims a cycle when cpu_addr[0] is 0, unless control bit 2 is 1 or the latched inhibit is 1. During a claimed cycle ula_en is 1 while cpu_iorq_n is 0.
- R5: The sound device claims a cycle when cpu_addr is 16'hFFFD or 16'hBFFD, unless control bit 1 is 1. During a claimed cycle snd_en is 1 while cpu_iorq_n is 0.
- R6: The inhibit value used by R4 is the ext_inhibit value sampled at the last clock edge at which cpu_iorq_n was 1. Changes on ext_inhibit while cpu_iorq_n stays 0 have no effect.
- R7: With the bus on, a cycle that no internal device claims is forwarded: bus_iorq_n, bus_rd_n and bus_wr_n follow the CPU strobes. A claimed cycle keeps all three bus strobes at 1. bus_addr follows cpu_addr whenever the bus is on.
- R8: A write through ctl_we loads ctl_wdata into the control register at the next rising clock edge. The bits are: bit 0 bus on, bit 1 sound device off, bit 2 even-port device off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_iorq_n | input | 1 | CPU I/O request, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 3 | Control register write data |
| speed_req | input | 2 | Requested CPU speed |
| ext_inhibit | input | 1 | Inhibit line from the connector, high suppresses the even-port device |
| bus_addr | output | 16 | Address bus driven to the connector |
| bus_iorq_n | output | 1 | Gated I/O request to the connector |
| bus_rd_n | output | 1 | Gated read strobe to the connector |
| bus_wr_n | output | 1 | Gated write strobe to the connector |
| ula_en | output | 1 | Enable for the internal even-port device |
| snd_en | output | 1 | Enable for the internal sound device |
| speed_eff | output | 2 | Effective CPU speed |

## Verification
The assertions assume that the CPU strobes and the address change only away from the rising edge and are stable at each edge. They also assume that ext_inhibit is settled at the last edge before cpu_iorq_n falls. The bench drives every input on the falling edge and holds each I/O cycle for at least one full clock with the address unchanged, so both assumptions hold. To show that the latched value wins, the bench deliberately toggles ext_inhibit during a strobe.

// File: rtl/xbg_pkg.sv
package xbg_pkg;
  localparam int XBG_AW  = 16;
  localparam int XBG_SPW = 2;

  typedef struct packed {
    logic ula_off;  // bit 2
    logic snd_off;  // bit 1
    logic bus_on;   // bit 0
  } xbg_ctl_t;

  localparam int XBG_CTL_W = $bits(xbg_ctl_t);

  function automatic logic even_port(input logic a0);
    return ~a0;
  endfunction

  function automatic logic [XBG_SPW-1:0] clamp_speed(input logic on,
                                                      input logic [XBG_SPW-1:0] req);
    return on ? '0 : req;
  endfunction
endpackage

// File: rtl/xbg_ctl_reg.sv
module xbg_ctl_reg
  import xbg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [XBG_CTL_W-1:0] wdata,
  output xbg_ctl_t             ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n)  ctl <= '0;
    else if (we) ctl <= xbg_ctl_t'(wdata);
  end

  // R1: the register is cleared when reset is released
  assert_ctl_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ctl == '0));
  // R8: a write lands at the next edge
  assert_ctl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctl == xbg_ctl_t'($past(wdata))));
endmodule

// File: rtl/xbg_inhibit_latch.sv
module xbg_inhibit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic iorq_n,
  input  logic inhibit,
  output logic inh_q
);
  wire strobe_idle = iorq_n;

  always_ff @(posedge clk) begin
    if (!rst_n)           inh_q <= 1'b0;
    else if (strobe_idle) inh_q <= inhibit;
  end

  // R6: held for as long as the strobe stays active
  assert_inh_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && $past(!iorq_n) && $past(rst_n)) |-> $stable(inh_q));
endmodule

// File: rtl/xbg_port_decode.sv
module xbg_port_decode
  import xbg_pkg::*;
#(
  parameter int              ADDR_W = XBG_AW,
  parameter logic [ADDR_W-1:0] SND_A = 16'hFFFD,
  parameter logic [ADDR_W-1:0] SND_B = 16'hBFFD
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  xbg_ctl_t          ctl,
  input  logic              inh_q,
  output logic              ula_hit,
  output logic              snd_hit,
  output logic              claimed,
  output logic              ula_en,
  output logic              snd_en
);
  logic ula_port, snd_port;

  always_comb begin
    ula_port = even_port(addr[0]);
    snd_port = (addr == SND_A) || (addr == SND_B);
    ula_hit  = ula_port && !ctl.ula_off && !inh_q;
    snd_hit  = snd_port && !ctl.snd_off;
    claimed  = ula_hit || snd_hit;
    ula_en   = ula_hit && !iorq_n;
    snd_en   = snd_hit && !iorq_n;
  end
endmodule

// File: rtl/xbg_strobe_gate.sv
module xbg_strobe_gate
  import xbg_pkg::*;
#(
  parameter int ADDR_W = XBG_AW
) (
  input  logic               bus_on,
  input  logic               claimed,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               iorq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [XBG_SPW-1:0] speed_req,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic               bus_iorq_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic               fwd,
  output logic [XBG_SPW-1:0] speed_eff
);
  always_comb begin
    fwd        = bus_on && !claimed;
    bus_addr   = bus_on ? addr : '0;
    bus_iorq_n = !(fwd && !iorq_n);
    bus_rd_n   = !(fwd && !iorq_n && !rd_n);
    bus_wr_n   = !(fwd && !iorq_n && !wr_n);
    speed_eff  = clamp_speed(bus_on, speed_req);
  end
endmodule

// File: rtl/xbus_io_gate.sv
module xbus_io_gate
  import xbg_pkg::*;
#(
  parameter int              ADDR_W = XBG_AW,
  parameter logic [ADDR_W-1:0] SND_A = 16'hFFFD,
  parameter logic [ADDR_W-1:0] SND_B = 16'hBFFD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_iorq_n,
  input  logic               cpu_rd_n,
  input  logic               cpu_wr_n,
  input  logic               ctl_we,
  input  logic [XBG_CTL_W-1:0] ctl_wdata,
  input  logic [XBG_SPW-1:0] speed_req,
  input  logic               ext_inhibit,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic               bus_iorq_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic               ula_en,
  output logic               snd_en,
  output logic [XBG_SPW-1:0] speed_eff
);
  xbg_ctl_t ctl;
  logic     inh_q, ula_hit, snd_hit, claimed, fwd;

  xbg_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .ctl(ctl));

  xbg_inhibit_latch u_inh (
    .clk(clk), .rst_n(rst_n), .iorq_n(cpu_iorq_n), .inhibit(ext_inhibit),
    .inh_q(inh_q));

  xbg_port_decode #(.ADDR_W(ADDR_W), .SND_A(SND_A), .SND_B(SND_B)) u_dec (
    .addr(cpu_addr), .iorq_n(cpu_iorq_n), .ctl(ctl), .inh_q(inh_q),
    .ula_hit(ula_hit), .snd_hit(snd_hit), .claimed(claimed),
    .ula_en(ula_en), .snd_en(snd_en));

  xbg_strobe_gate #(.ADDR_W(ADDR_W)) u_gate (
    .bus_on(ctl.bus_on), .claimed(claimed), .addr(cpu_addr),
    .iorq_n(cpu_iorq_n), .rd_n(cpu_rd_n), .wr_n(cpu_wr_n),
    .speed_req(speed_req), .bus_addr(bus_addr), .bus_iorq_n(bus_iorq_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .fwd(fwd),
    .speed_eff(speed_eff));

  // R2: connector idle while the bus is off
  assert_bus_neutral_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.bus_on |-> (bus_iorq_n && bus_rd_n && bus_wr_n && bus_addr == '0));
  // R3: speed clamp while the bus is on
  assert_speed_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.bus_on |-> (speed_eff == '0));
  // R4: a claimed even-port cycle is not forwarded
  assert_ula_not_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ula_en |-> (bus_iorq_n && bus_rd_n && bus_wr_n));
  // R5: a claimed sound cycle is not forwarded
  assert_snd_not_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snd_en |-> (bus_iorq_n && bus_rd_n && bus_wr_n));
  // R7: a bus strobe only appears when forwarding
  assert_fwd_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_iorq_n |-> (fwd && !cpu_iorq_n && !ula_en && !snd_en));
endmodule

// File: tb/xbus_io_gate_bench.sv
module xbus_io_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_iorq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = 3'b000;
  logic [1:0]  speed_req = 2'b00;
  logic        ext_inhibit = 1'b0;
  logic [15:0] bus_addr;
  logic        bus_iorq_n, bus_rd_n, bus_wr_n, ula_en, snd_en;
  logic [1:0]  speed_eff;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  xbus_io_gate u_xbus_io_gate (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_iorq_n(cpu_iorq_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .speed_req(speed_req), .ext_inhibit(ext_inhibit),
    .bus_addr(bus_addr), .bus_iorq_n(bus_iorq_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .ula_en(ula_en), .snd_en(snd_en),
    .speed_eff(speed_eff));

  // Reference state
  bit m_on, m_sndoff, m_ulaoff, m_inh;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_sndoff = 0; m_ulaoff = 0; m_inh = 0;
    end else begin
      if (ctl_we) begin
        m_on = ctl_wdata[0]; m_sndoff = ctl_wdata[1]; m_ulaoff = ctl_wdata[2];
      end
      if (cpu_iorq_n == 1'b1) m_inh = ext_inhibit;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare every output with the reference for the current inputs
  task automatic compare(string tag);
    bit ula_want, snd_want, pass_out;
    int e_iorq, e_rd, e_wr, e_addr, e_spd;
    ula_want = 0; snd_want = 0;
    if (cpu_addr[0] == 1'b0 && !m_ulaoff && !m_inh) ula_want = 1;
    if ((cpu_addr == 16'hFFFD || cpu_addr == 16'hBFFD) && !m_sndoff) snd_want = 1;
    pass_out = m_on && !ula_want && !snd_want && !cpu_iorq_n;
    e_iorq = 1; e_rd = 1; e_wr = 1;
    if (pass_out) begin
      e_iorq = 0; e_rd = cpu_rd_n; e_wr = cpu_wr_n;
    end
    e_addr = m_on ? int'(cpu_addr) : 0;
    e_spd  = m_on ? 0 : int'(speed_req);
    chk(tag, "bus_iorq_n", bus_iorq_n, e_iorq);
    chk(tag, "bus_rd_n", bus_rd_n, e_rd);
    chk(tag, "bus_wr_n", bus_wr_n, e_wr);
    chk(tag, "bus_addr", bus_addr, e_addr);
    chk(tag, "ula_en", ula_en, int'(ula_want && !cpu_iorq_n));
    chk(tag, "snd_en", snd_en, int'(snd_want && !cpu_iorq_n));
    chk(tag, "speed_eff", speed_eff, e_spd);
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    #2 compare("R7");
  end

  task automatic write_ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  // One I/O cycle: two clocks of active strobe
  task automatic io(logic [15:0] a, bit rd, string tag);
    @(negedge clk);
    cpu_addr = a; cpu_iorq_n = 0; cpu_rd_n = !rd; cpu_wr_n = rd;
    #3 compare(tag);
    @(negedge clk); #3 compare(tag);
    @(negedge clk); cpu_iorq_n = 1; cpu_rd_n = 1; cpu_wr_n = 1;
  endtask

  initial begin
    fork
      begin
        #2000000;
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: actual=hung expected=finished");
          done = 1;
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    speed_req = 2'b11;
    repeat (3) @(negedge clk);
    #2 compare("R1");
    @(negedge clk); rst_n = 1;
    #2 compare("R1");
    chk("R1", "speed_eff passthrough", speed_eff, 3);

    // Bus off: nothing reaches the connector
    io(16'h00FE, 0, "R2");
    io(16'h12F7, 1, "R2");
    io(16'hFFFD, 0, "R2");
    speed_req = 2'b10;
    @(negedge clk); #2 compare("R3");

    // R8: write lands on the next edge
    @(negedge clk); ctl_we = 1; ctl_wdata = 3'b001;
    #2 chk("R8", "bus_addr before edge", bus_addr, 0);
    @(negedge clk); ctl_we = 0; cpu_addr = 16'h1234;
    #2 chk("R8", "bus_addr after edge", bus_addr, 16'h1234);
    chk("R3", "speed clamped", speed_eff, 0);

    // Bus on, default devices
    io(16'h00FE, 0, "R4");
    io(16'hFFFD, 1, "R5");
    io(16'hBFFD, 0, "R5");
    io(16'h7FFD, 0, "R7");
    io(16'h12F7, 1, "R7");
    io(16'h00DF, 1, "R7");

    // Internal devices off: their ports go out
    write_ctl(3'b011);
    io(16'hFFFD, 0, "R5");
    io(16'hBFFD, 1, "R5");
    io(16'h00FE, 1, "R4");
    write_ctl(3'b101);
    io(16'h00FE, 0, "R4");
    io(16'h10FC, 1, "R4");
    io(16'hFFFD, 0, "R5");

    // Inhibit
    write_ctl(3'b001);
    @(negedge clk); ext_inhibit = 1;
    io(16'h00FE, 1, "R6");
    // Inhibit sampled high before strobe, dropped mid-cycle
    @(negedge clk); cpu_addr = 16'h00FE; cpu_iorq_n = 0; cpu_rd_n = 0;
    ext_inhibit = 0;
    #3 compare("R6"); chk("R6", "ula_en stays off", ula_en, 0);
    @(negedge clk); #3 compare("R6");
    chk("R6", "forwarded", bus_iorq_n, 0);
    @(negedge clk); cpu_iorq_n = 1; cpu_rd_n = 1;
    // Sampled low, raised mid-cycle
    @(negedge clk); cpu_iorq_n = 0; cpu_wr_n = 0; ext_inhibit = 1;
    #3 chk("R6", "ula_en claimed", ula_en, 1);
    @(negedge clk); #3 chk("R6", "ula_en held", ula_en, 1);
    chk("R6", "not forwarded", bus_iorq_n, 1);
    @(negedge clk); cpu_iorq_n = 1; cpu_wr_n = 1; ext_inhibit = 0;

    // Sweep of addresses and modes
    for (int m = 0; m < 8; m++) begin
      write_ctl(m[2:0]);
      speed_req = m[1:0];
      for (int k = 0; k < 12; k++) begin
        logic [15:0] a;
        a = 16'(k * 16'h1537 + m);
        if (k == 3) a = 16'hFFFD;
        if (k == 7) a = 16'hBFFD;
        ext_inhibit = k[2];
        @(negedge clk);
        io(a, k[0], "R7");
      end
    end

    // Reset mid-run clears control
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; speed_req = 2'b01;
    #2 chk("R1", "bus_addr after reset", bus_addr, 0);
    chk("R1", "speed after reset", speed_eff, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule